// File: doc/BRIEF.md
# Supervisor Timer Compare Register Unit

This unit holds the 64-bit deadline that supervisor software programs for its next timer interrupt. It compares the deadline against a free-running time value every cycle and drives the supervisor timer interrupt-pending bit. The pending bit is set whenever the deadline is at or behind the current time, so a deadline written in the past raises the interrupt at once.

The unit sits beside a core's CSR file. It decodes two CSR addresses: one for the low half or the full register, and one for the upper half, which exists only in 32-bit mode. It checks each access against several conditions: the feature strap, a present time source, the current privilege level, and the two enable bits set by machine software. It then either performs the access or flags an illegal instruction.

The unit also tells the interrupt-pending register when software writes to the supervisor and virtual-supervisor timer pending bits must be dropped. This happens because, while the feature is active, those bits are owned by the hardware comparison.

Top module: `sup_timer_cmp`

## Requirements
- R1: After reset the compare register reads as zero. Because zero is at or behind any time value, the pending output is 1 after reset.
- R2: Any read or write to either address (0x14D, 0x15D) raises illegalInst when extEnable is 0 or timeValid is 0. Such a write leaves the register unchanged.
- R3: With extEnable and timeValid both 1, machine mode (privLvl 3) may access 0x14D whatever the values of cntEnTm and envStce.
- R4: In supervisor mode (privLvl 1), an access is legal only when cntEnTm and envStce are both 1. Otherwise it raises illegalInst, and an illegal write leaves the register unchanged.
- R5: In user mode (privLvl 0), an access always raises illegalInst, even with both enable bits set.
- R6: An access to 0x15D raises illegalInst when isRv32 is 0.
- R7: In 32-bit mode (isRv32=1), a write to 0x14D replaces only bits 31:0 and a write to 0x15D replaces only bits 63:32. In both cases the new bits are taken from csrWdata[31:0].
- R8: In 64-bit mode, a write to 0x14D replaces all 64 bits and a read returns all 64 bits. In 32-bit mode, a read of 0x14D returns bits 31:0 with zeros above.
- R9: A legal read of 0x15D returns register bits 63:32 in csrRdata[31:0], with zeros above. csrRdata is zero for any illegal access.
- R10: stipPending is 1 exactly when the compare value is less than or equal to timeNow, using an unsigned 64-bit comparison.
- R11: pendWrMask is 2'b00 (bit 0 is the supervisor timer pending bit, bit 1 is the virtual-supervisor one) when extEnable=1, envStce=1 and privLvl=3. In every other case it is 2'b11.
- R12: After a legal write, stipPending reflects the new compare value from the first clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Current free-running time value |
| csrAddr | input | 12 | CSR address of the access |
| csrRd | input | 1 | Read strobe |
| csrWr | input | 1 | Write strobe |
| csrWdata | input | 64 | Write data |
| privLvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| isRv32 | input | 1 | 1 when the core runs in 32-bit mode |
| extEnable | input | 1 | Feature strap |
| timeValid | input | 1 | A time source is present |
| cntEnTm | input | 1 | Time bit of the machine counter-enable register |
| envStce | input | 1 | Timer-compare enable bit of the machine environment-config register |
| csrRdata | output | 64 | Read data |
| illegalInst | output | 1 | Access is illegal |
| stipPending | output | 1 | Supervisor timer interrupt pending |
| pendWrMask | output | 2 | Software write mask for the STIP (bit 0) and VSTIP (bit 1) pending bits |

## Verification
The bench builds the unit with its default parameters: a 64-bit time width, a 12-bit address and the two standard addresses. At this width, the pending comparison can be driven across the sign boundary at bit 63, where a signed compare would go wrong. Full 64-bit words also make it easy to see that a 32-bit half write left the other half untouched. A vector table walks the privilege, mode and enable combinations against both addresses. Directed tests then cover reset, compare equality and the cycle after a write.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  // strobes handed from the access control to the datapath
  typedef struct packed {
    logic wrLo;      // replace low half only
    logic wrHi;      // replace high half only
    logic wrFull;    // replace the whole register
    logic rdEn;      // legal read in progress
    logic rdHi;      // read returns the high half
    logic rdNarrow;  // read returns the low half, zero extended
  } strobe_t;
endpackage

// File: rtl/stc_access_ctrl.sv
module stc_access_ctrl
  import stc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'h14D,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'h15D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrRd,
  input  logic              csrWr,
  input  logic [1:0]        privLvl,
  input  logic              isRv32,
  input  logic              extEnable,
  input  logic              timeValid,
  input  logic              cntEnTm,
  input  logic              envStce,
  output logic              illegal,
  output strobe_t           strb,
  output logic [1:0]        pendWrMask
);
  logic anyAccess, hitLo, hitHi, featureOk, privOk, widthOk, legal;

  always_comb begin
    anyAccess = csrRd | csrWr;
    hitLo     = (csrAddr == LO_ADDR);
    hitHi     = (csrAddr == HI_ADDR);
    featureOk = extEnable & timeValid;
    // machine mode passes outright; lower modes need both enables and at least S
    privOk    = (privLvl == PRIV_M) |
                (cntEnTm & envStce & (privLvl == PRIV_S));
    widthOk   = hitLo | (hitHi & isRv32);
    legal     = featureOk & privOk & widthOk;
    illegal   = anyAccess & (hitLo | hitHi) & ~legal;

    strb.wrLo     = csrWr & legal & hitLo & isRv32;
    strb.wrFull   = csrWr & legal & hitLo & ~isRv32;
    strb.wrHi     = csrWr & legal & hitHi;
    strb.rdEn     = csrRd & legal;
    strb.rdHi     = hitHi;
    strb.rdNarrow = isRv32;

    pendWrMask = (extEnable & envStce & (privLvl == PRIV_M)) ? 2'b00 : 2'b11;
  end

  p_noext_illegal_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((csrRd || csrWr) && (csrAddr == LO_ADDR || csrAddr == HI_ADDR) &&
     !(extEnable && timeValid)) |-> illegal);

  p_mach_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((csrRd || csrWr) && csrAddr == LO_ADDR && privLvl == PRIV_M &&
     extEnable && timeValid) |-> !illegal);

  p_illegal_no_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !(strb.wrLo || strb.wrHi || strb.wrFull || strb.rdEn));

  p_user_illegal_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((csrRd || csrWr) && csrAddr == LO_ADDR && privLvl == PRIV_U) |-> illegal);

  p_hi_rv64_illegal_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((csrRd || csrWr) && csrAddr == HI_ADDR && !isRv32) |-> illegal);
endmodule

// File: rtl/stc_cmp_datapath.sv
module stc_cmp_datapath
  import stc_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [TIME_W-1:0] wrData,
  input  logic [TIME_W-1:0] timeNow,
  output logic [TIME_W-1:0] cmpVal,
  output logic [TIME_W-1:0] rdData,
  output logic              pending
);
  localparam int HALF_W = TIME_W / 2;

  logic [TIME_W-1:0] cmpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (strb.wrFull) begin
      cmpQ <= wrData;
    end else begin
      if (strb.wrLo) cmpQ[HALF_W-1:0]      <= wrData[HALF_W-1:0];
      if (strb.wrHi) cmpQ[TIME_W-1:HALF_W] <= wrData[HALF_W-1:0];
    end
  end

  always_comb begin
    if (!strb.rdEn)         rdData = '0;
    else if (strb.rdHi)     rdData = {{HALF_W{1'b0}}, cmpQ[TIME_W-1:HALF_W]};
    else if (strb.rdNarrow) rdData = {{HALF_W{1'b0}}, cmpQ[HALF_W-1:0]};
    else                    rdData = cmpQ;
  end

  // deadline at or behind the current time raises the interrupt
  assign pending = (cmpQ <= timeNow);
  assign cmpVal  = cmpQ;

  p_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHi && !strb.wrFull) |=> cmpQ[HALF_W-1:0] == $past(cmpQ[HALF_W-1:0]));

  p_lo_keeps_hi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLo && !strb.wrHi && !strb.wrFull) |=>
      cmpQ[TIME_W-1:HALF_W] == $past(cmpQ[TIME_W-1:HALF_W]));

  p_full_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFull |=> cmpQ == $past(wrData));
endmodule

// File: rtl/sup_timer_cmp.sv
module sup_timer_cmp
  import stc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'h14D,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'h15D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrRd,
  input  logic              csrWr,
  input  logic [TIME_W-1:0] csrWdata,
  input  logic [1:0]        privLvl,
  input  logic              isRv32,
  input  logic              extEnable,
  input  logic              timeValid,
  input  logic              cntEnTm,
  input  logic              envStce,
  output logic [TIME_W-1:0] csrRdata,
  output logic              illegalInst,
  output logic              stipPending,
  output logic [1:0]        pendWrMask
);
  strobe_t           strb;
  logic [TIME_W-1:0] cmpVal;

  stc_access_ctrl #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csrAddr   (csrAddr),
    .csrRd     (csrRd),
    .csrWr     (csrWr),
    .privLvl   (privLvl),
    .isRv32    (isRv32),
    .extEnable (extEnable),
    .timeValid (timeValid),
    .cntEnTm   (cntEnTm),
    .envStce   (envStce),
    .illegal   (illegalInst),
    .strb      (strb),
    .pendWrMask(pendWrMask)
  );

  stc_cmp_datapath #(
    .TIME_W(TIME_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (csrWdata),
    .timeNow(timeNow),
    .cmpVal (cmpVal),
    .rdData (csrRdata),
    .pending(stipPending)
  );

  p_illegal_write_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrWr && illegalInst) |=> $stable(cmpVal));

  p_mask_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (extEnable && envStce && privLvl == PRIV_M) |-> pendWrMask == 2'b00);

  p_illegal_zero_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegalInst |-> csrRdata == '0);
endmodule

// File: tb/sim_sup_timer_cmp.sv
module sim_sup_timer_cmp;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] timeNow;
  logic [11:0] csrAddr;
  logic        csrRd, csrWr;
  logic [63:0] csrWdata;
  logic [1:0]  privLvl;
  logic        isRv32, extEnable, timeValid, cntEnTm, envStce;
  logic [63:0] csrRdata;
  logic        illegalInst, stipPending;
  logic [1:0]  pendWrMask;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sup_timer_cmp u0 (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .csrAddr(csrAddr),
    .csrRd(csrRd), .csrWr(csrWr), .csrWdata(csrWdata), .privLvl(privLvl),
    .isRv32(isRv32), .extEnable(extEnable), .timeValid(timeValid),
    .cntEnTm(cntEnTm), .envStce(envStce), .csrRdata(csrRdata),
    .illegalInst(illegalInst), .stipPending(stipPending), .pendWrMask(pendWrMask)
  );

  typedef struct packed {
    logic [1:0]  priv;
    logic        rv32, ext, tv, tm, stce;
    logic [11:0] addr;
    logic        wr;
    logic [63:0] wdata;
    logic        expIll;
    logic [63:0] expRd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,12'h14D,1'b0,64'h0,1'b0,64'h0,4'd3},                           // R3 machine, enables clear
    '{2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,12'h14D,1'b1,64'h1234_5678_9ABC_DEF0,1'b0,64'h0,4'd8},         // R8 full write
    '{2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,12'h14D,1'b0,64'h0,1'b0,64'h1234_5678_9ABC_DEF0,4'd8},         // R8 full read
    '{2'd1,1'b0,1'b1,1'b1,1'b0,1'b1,12'h14D,1'b1,64'h5,1'b1,64'h0,4'd4},                           // R4 TM clear
    '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,12'h14D,1'b0,64'h0,1'b1,64'h0,4'd4},                           // R4 STCE clear
    '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b0,64'h1234_5678_9ABC_DEF0,4'd4},         // R4 both set, earlier write ignored
    '{2'd0,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b1,64'h0,4'd5},                           // R5 user
    '{2'd3,1'b0,1'b1,1'b1,1'b1,1'b1,12'h15D,1'b0,64'h0,1'b1,64'h0,4'd6},                           // R6 high half in RV64
    '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b1,12'h15D,1'b0,64'h0,1'b0,64'h0000_0000_1234_5678,4'd9},         // R9 high read
    '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b1,64'hFFFF_FFFF_AAAA_BBBB,1'b0,64'h0,4'd7},         // R7 low write
    '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b0,64'h0000_0000_AAAA_BBBB,4'd8},         // R8 narrow read
    '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b1,12'h15D,1'b1,64'h77,1'b0,64'h0,4'd7},                          // R7 high write
    '{2'd3,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b0,64'h0000_0077_AAAA_BBBB,4'd7},         // R7 both halves
    '{2'd3,1'b0,1'b0,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b1,64'h0,4'd2},                           // R2 strap off
    '{2'd3,1'b0,1'b1,1'b0,1'b1,1'b1,12'h14D,1'b1,64'h0,1'b1,64'h0,4'd2},                           // R2 no time source
    '{2'd3,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b0,64'h0000_0077_AAAA_BBBB,4'd2}          // R2 write ignored
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    privLvl = v.priv; isRv32 = v.rv32; extEnable = v.ext; timeValid = v.tv;
    cntEnTm = v.tm; envStce = v.stce; csrAddr = v.addr;
    csrWr = v.wr; csrRd = !v.wr; csrWdata = v.wdata;
  endtask

  task automatic finishAccess();
    @(posedge clk); #1;
    csrRd = 1'b0; csrWr = 1'b0;
  endtask

  task automatic mWrite64(input logic [63:0] d);
    vec_t v;
    v = '{2'd3,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b1,d,1'b0,64'h0,4'd0};
    drive(v);
    finishAccess();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; timeNow = 64'h0; csrAddr = 12'h0; csrRd = 1'b0; csrWr = 1'b0;
    csrWdata = 64'h0; privLvl = 2'd3; isRv32 = 1'b0; extEnable = 1'b1;
    timeValid = 1'b1; cntEnTm = 1'b0; envStce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    #1 chk(stipPending == 1'b1, "R1 pending after reset", {63'h0, stipPending}, 64'h1);

    timeNow = 64'h0000_0001_0000_0000;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      #1;
      chk(illegalInst == VECS[i].expIll, $sformatf("R%0d illegal vec %0d", VECS[i].req, i),
          {63'h0, illegalInst}, {63'h0, VECS[i].expIll});
      if (!VECS[i].wr)
        chk(csrRdata == VECS[i].expRd, $sformatf("R%0d rdata vec %0d", VECS[i].req, i),
            csrRdata, VECS[i].expRd);
      finishAccess();
    end

    // R9 illegal access reads zero
    drive('{2'd0,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b0,64'h0,1'b1,64'h0,4'd9});
    #1 chk(csrRdata == 64'h0, "R9 illegal read zero", csrRdata, 64'h0);
    finishAccess();

    // R10 threshold and equality
    mWrite64(64'd100);
    @(negedge clk); timeNow = 64'd99;
    #1 chk(stipPending == 1'b0, "R10 time below compare", {63'h0, stipPending}, 64'h0);
    timeNow = 64'd100;
    #1 chk(stipPending == 1'b1, "R10 time equal compare", {63'h0, stipPending}, 64'h1);
    timeNow = 64'd101;
    #1 chk(stipPending == 1'b1, "R10 time above compare", {63'h0, stipPending}, 64'h1);

    // R10 unsigned across bit 63
    mWrite64(64'h8000_0000_0000_0000);
    @(negedge clk); timeNow = 64'h7FFF_FFFF_FFFF_FFFF;
    #1 chk(stipPending == 1'b0, "R10 unsigned below", {63'h0, stipPending}, 64'h0);
    timeNow = 64'h8000_0000_0000_0000;
    #1 chk(stipPending == 1'b1, "R10 unsigned equal", {63'h0, stipPending}, 64'h1);

    // R12 pending follows a past deadline right after the write edge
    @(negedge clk); timeNow = 64'd50;
    #1 chk(stipPending == 1'b0, "R12 before write", {63'h0, stipPending}, 64'h0);
    drive('{2'd3,1'b0,1'b1,1'b1,1'b1,1'b1,12'h14D,1'b1,64'd40,1'b0,64'h0,4'd12});
    #1 chk(stipPending == 1'b0, "R12 same cycle as write", {63'h0, stipPending}, 64'h0);
    finishAccess();
    chk(stipPending == 1'b1, "R12 after write edge", {63'h0, stipPending}, 64'h1);

    // R11 write mask
    @(negedge clk); privLvl = 2'd3; extEnable = 1'b1; envStce = 1'b1;
    #1 chk(pendWrMask == 2'b00, "R11 machine locked", {62'h0, pendWrMask}, 64'h0);
    privLvl = 2'd1;
    #1 chk(pendWrMask == 2'b11, "R11 supervisor open", {62'h0, pendWrMask}, 64'h3);
    privLvl = 2'd3; envStce = 1'b0;
    #1 chk(pendWrMask == 2'b11, "R11 STCE clear open", {62'h0, pendWrMask}, 64'h3);
    envStce = 1'b1; extEnable = 1'b0;
    #1 chk(pendWrMask == 2'b11, "R11 strap off open", {62'h0, pendWrMask}, 64'h3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule